// File: doc/BRIEF.md
# TLB-Backed Address Translator

This block maps 32-bit logical addresses onto a 24-bit physical space made of 4 KB pages. The low 12 bits of the logical address are the byte offset and go straight through. The upper 20 bits are the virtual page number, and they are looked up in a 64-entry fully associative translation buffer. On a hit the physical address comes back on the next cycle. On a miss the block reads one line of an external linear page table, indexed by the virtual page number, through a request/ready read port. A valid entry is used for the result and written into the buffer. An entry whose valid bit is clear is reported as a fault and is not translated.

A requester presents an address with `req_valid` while `req_ready` is high. Only one translation is in flight at a time, and `req_ready` stays low while a table walk is pending. A global `flush` input clears every buffer entry in one cycle, for example after the page table has been rewritten.

Top module: `addr_xlate`

## Requirements
- R1: The physical address is {frame number, offset}. The frame number is 12 bits and the offset is the logical address bits [11:0], copied unchanged.
- R2: When the virtual page number (bits [31:12]) hits in the buffer, `resp_done` is high with the translation in the cycle after acceptance, and `pt_rd_en` never rises.
- R3: On a miss, `pt_rd_en` is high from the cycle after acceptance, with `pt_rd_vpn` equal to the virtual page number. It is held until `pt_rd_ready` is sampled high. `resp_done` follows in the next cycle.
- R4: A page-table word has the valid bit at bit 12 and the frame number in bits [11:0]. A word with bit 12 clear gives `resp_fault`=1 with `resp_paddr`=0 and is not installed, so a repeat of the same page walks again.
- R5: A valid fetched entry is installed. Later requests to that page hit and return the cached frame, even if the table has changed since.
- R6: An install uses the lowest-numbered free entry when one exists, so 64 distinct pages all stay resident.
- R7: When all 64 entries are valid, the victim is chosen by a round-robin pointer that starts at entry 0 and advances by one on each replacement.
- R8: `flush` clears all entries in one cycle. An install on the same edge is dropped, and `req_ready` is low while `flush` is high.
- R9: `req_ready` is high only when no walk is pending and `flush` is low. Requests offered while it is low are not taken.
- R10: After reset, `req_ready`=1, `resp_done`=0, `pt_rd_en`=0 and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Logical address |
| req_ready | output | 1 | Block can take a request this cycle |
| flush | input | 1 | Clear every buffer entry |
| pt_rd_en | output | 1 | Page-table read request, held until answered |
| pt_rd_vpn | output | 20 | Page-table line index (virtual page number) |
| pt_rd_ready | input | 1 | Page-table word valid this cycle |
| pt_rd_data | input | 13 | Page-table word: bit 12 valid, [11:0] frame |
| resp_done | output | 1 | Translation result valid this cycle |
| resp_paddr | output | 24 | Physical address (0 on fault) |
| resp_fault | output | 1 | Access hit an invalid page |

## Verification
The checker watches every cycle for these rules. The walk index matches the accepted page and stays stable until the table answers. The result arrives exactly one cycle after the table answers. An invalid word always yields a fault with a zero address. The offset of a successful result equals the accepted offset, and `req_ready` is low during a walk and during a flush. The bench scenarios show what only a request history reveals: hits that skip the walk, stale cached frames after a table change, refetches after a flush, an install dropped by a coinciding flush, and the lowest-free-first and round-robin replacement order over a full buffer.

// File: rtl/xlt_pkg.sv
// Shared widths and types for the address translator.
// Assumes 4 KB pages (12-bit offset), a 32-bit logical space and a 24-bit physical space.
package xlt_pkg;
    localparam int VA_W  = 32;
    localparam int OFF_W = 12;
    localparam int PA_W  = 24;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PFN_W = PA_W - OFF_W;

    // Page-table word: valid flag above the frame number.
    typedef struct packed {
        logic             valid;
        logic [PFN_W-1:0] pfn;
    } pte_t;

    typedef enum logic {ST_IDLE, ST_WALK} xlt_state_e;
endpackage

// File: rtl/xlt_victim.sv
// Chooses the buffer slot for the next install.
// Takes the lowest free slot; when none is free, takes a round-robin pointer
// that advances once per replacement. Assumes at most one install per cycle.
module xlt_victim #(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               bump,
    output logic [IDX_W-1:0]   widx
);
    logic [IDX_W-1:0] free_idx;
    logic             any_free;
    logic [IDX_W-1:0] rr_ptr;

    // Priority search for the lowest-numbered invalid slot.
    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end

    assign widx = any_free ? free_idx : rr_ptr;

    // Advance the replacement pointer only when an occupied slot is overwritten.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (bump && !any_free) begin
            rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/xlt_tlb.sv
// Fully associative translation buffer.
// Combinational lookup on lk_vpn; single-port install; flush clears all valid
// bits and overrides an install on the same edge. Assumes no duplicate tags,
// which holds because installs happen only after a miss.
module xlt_tlb #(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 12,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PFN_W-1:0] wr_pfn,
    input  logic             flush
);
    logic [ENTRIES-1:0] valid_q;
    logic [VPN_W-1:0]   tag_q [ENTRIES];
    logic [PFN_W-1:0]   pfn_q [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0]   widx;

    // One comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid_q[g] && (tag_q[g] == lk_vpn);
    end

    assign lk_hit = |match;

    // OR-mux of the (at most one) matching frame number.
    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            lk_pfn = lk_pfn | (match[i] ? pfn_q[i] : '0);
        end
    end

    xlt_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_vec(valid_q),
        .bump     (wr_en && !flush),
        .widx     (widx)
    );

    // Valid bits: reset and flush clear them, an install sets one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[widx] <= 1'b1;
        end
    end

    // Tag and frame storage; contents are don't-care while the valid bit is clear.
    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            tag_q[widx] <= wr_vpn;
            pfn_q[widx] <= wr_pfn;
        end
    end
endmodule

// File: rtl/xlt_walker.sv
// Request sequencer: accepts one request while idle, answers hits on the next
// cycle, otherwise walks the external page table and answers one cycle after
// the word returns. Assumes the table holds pt_rd_ready low until it answers.
module xlt_walker
    import xlt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             req_ready,
    input  logic             flush,
    output logic [VPN_W-1:0] lk_vpn,
    input  logic             lk_hit,
    input  logic [PFN_W-1:0] lk_pfn,
    output logic             pt_rd_en,
    output logic [VPN_W-1:0] pt_rd_vpn,
    input  logic             pt_rd_ready,
    input  pte_t             pte,
    output logic             wr_en,
    output logic [VPN_W-1:0] wr_vpn,
    output logic [PFN_W-1:0] wr_pfn,
    output logic             resp_done,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             resp_fault
);
    xlt_state_e       state;
    logic [VPN_W-1:0] vpn_q;
    logic [OFF_W-1:0] off_q;
    logic             done_q;
    logic             fault_q;
    logic [PA_W-1:0]  pa_q;
    logic             accept;
    logic             walk_ret;

    assign req_ready = (state == ST_IDLE) && !flush;
    assign accept    = req_valid && req_ready;
    assign lk_vpn    = req_vaddr[VA_W-1:OFF_W];
    assign pt_rd_en  = (state == ST_WALK);
    assign pt_rd_vpn = vpn_q;
    assign walk_ret  = pt_rd_en && pt_rd_ready;
    assign wr_en     = walk_ret && pte.valid && !flush;
    assign wr_vpn    = vpn_q;
    assign wr_pfn    = pte.pfn;

    // Sequencing and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            vpn_q   <= '0;
            off_q   <= '0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            pa_q    <= '0;
        end else begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        vpn_q <= lk_vpn;
                        off_q <= req_vaddr[OFF_W-1:0];
                        if (lk_hit) begin
                            done_q <= 1'b1;
                            pa_q   <= {lk_pfn, req_vaddr[OFF_W-1:0]};
                        end else begin
                            state <= ST_WALK;
                        end
                    end
                end
                ST_WALK: begin
                    if (pt_rd_ready) begin
                        done_q  <= 1'b1;
                        fault_q <= !pte.valid;
                        pa_q    <= pte.valid ? {pte.pfn, off_q} : '0;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign resp_done  = done_q;
    assign resp_fault = fault_q;
    assign resp_paddr = pa_q;
endmodule

// File: rtl/addr_xlate.sv
// Top of the address translator: a sequencer in front of a fully associative
// buffer, with a linear page table reached through an external read port.
// Assumes a single outstanding translation.
module addr_xlate
    import xlt_pkg::*;
#(
    parameter int TLB_ENTRIES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             req_ready,
    input  logic             flush,
    output logic             pt_rd_en,
    output logic [VPN_W-1:0] pt_rd_vpn,
    input  logic             pt_rd_ready,
    input  logic [PFN_W:0]   pt_rd_data,
    output logic             resp_done,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             resp_fault
);
    logic [VPN_W-1:0] lk_vpn;
    logic             lk_hit;
    logic [PFN_W-1:0] lk_pfn;
    logic             wr_en;
    logic [VPN_W-1:0] wr_vpn;
    logic [PFN_W-1:0] wr_pfn;
    pte_t             pte;

    assign pte = pte_t'(pt_rd_data);

    xlt_walker u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_vaddr  (req_vaddr),
        .req_ready  (req_ready),
        .flush      (flush),
        .lk_vpn     (lk_vpn),
        .lk_hit     (lk_hit),
        .lk_pfn     (lk_pfn),
        .pt_rd_en   (pt_rd_en),
        .pt_rd_vpn  (pt_rd_vpn),
        .pt_rd_ready(pt_rd_ready),
        .pte        (pte),
        .wr_en      (wr_en),
        .wr_vpn     (wr_vpn),
        .wr_pfn     (wr_pfn),
        .resp_done  (resp_done),
        .resp_paddr (resp_paddr),
        .resp_fault (resp_fault)
    );

    xlt_tlb #(
        .ENTRIES(TLB_ENTRIES),
        .VPN_W  (VPN_W),
        .PFN_W  (PFN_W)
    ) u_tlb (
        .clk   (clk),
        .rst_n (rst_n),
        .lk_vpn(lk_vpn),
        .lk_hit(lk_hit),
        .lk_pfn(lk_pfn),
        .wr_en (wr_en),
        .wr_vpn(wr_vpn),
        .wr_pfn(wr_pfn),
        .flush (flush)
    );
endmodule

// File: rtl/xlt_chk.sv
// Port-level protocol checker for addr_xlate, bound to every instance.
// Keeps its own copy of the last accepted page and offset.
module xlt_chk
    import xlt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             req_ready,
    input logic             flush,
    input logic             pt_rd_en,
    input logic [VPN_W-1:0] pt_rd_vpn,
    input logic             pt_rd_ready,
    input logic [PFN_W:0]   pt_rd_data,
    input logic             resp_done,
    input logic [PA_W-1:0]  resp_paddr,
    input logic             resp_fault
);
    logic [VPN_W-1:0] chk_vpn;
    logic [OFF_W-1:0] chk_off;

    // Remember what was accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_vpn <= '0;
            chk_off <= '0;
        end else if (req_valid && req_ready) begin
            chk_vpn <= req_vaddr[VA_W-1:OFF_W];
            chk_off <= req_vaddr[OFF_W-1:0];
        end
    end

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done && !resp_fault |-> resp_paddr[OFF_W-1:0] == chk_off); // R1
    AST_FRAME_FROM_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        pt_rd_en && pt_rd_ready && pt_rd_data[PFN_W] |=>
        resp_paddr[PA_W-1:OFF_W] == $past(pt_rd_data[PFN_W-1:0])); // R1
    AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |-> $past(req_valid && req_ready) || $past(pt_rd_en && pt_rd_ready)); // R2
    AST_WALK_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        pt_rd_en |-> pt_rd_vpn == chk_vpn); // R3
    AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pt_rd_en && !pt_rd_ready |=> pt_rd_en && $stable(pt_rd_vpn)); // R3
    AST_MISS_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        pt_rd_en && pt_rd_ready |=> resp_done && !pt_rd_en); // R3
    AST_TRAP_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        pt_rd_en && pt_rd_ready && !pt_rd_data[PFN_W] |=> resp_fault && resp_paddr == '0); // R4
    AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !req_ready); // R8
    AST_STALL_WHILE_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        pt_rd_en |-> !req_ready); // R9
endmodule

bind addr_xlate xlt_chk u_chk (.*);

// File: tb/addr_xlate_tb.sv
`timescale 1ns/1ps
module addr_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready;
    logic        flush = 1'b0;
    logic        pt_rd_en;
    logic [19:0] pt_rd_vpn;
    logic        pt_rd_ready = 1'b0;
    logic [12:0] pt_rd_data = '0;
    logic        resp_done;
    logic [23:0] resp_paddr;
    logic        resp_fault;

    int          total = 0;
    int          bad = 0;
    logic [11:0] salt = '0;
    int          lat = 0;

    always #4 clk = ~clk;

    addr_xlate u_dut (.*);

    // Page-table model contents: bit 12 valid, [11:0] frame.
    function automatic logic [12:0] pt_word(logic [19:0] vpn, logic [11:0] s);
        logic v;
        v = (vpn[19:12] != 8'h0B);
        return {v, vpn[11:0] ^ {vpn[19:12], 4'h0} ^ s};
    endfunction

    function automatic logic [23:0] exp_pa(logic [31:0] va, logic [11:0] s);
        logic [12:0] w;
        w = pt_word(va[31:12], s);
        return w[12] ? {w[11:0], va[11:0]} : 24'h0;
    endfunction

    // Page-table responder: answers after lat idle cycles, one-cycle ready.
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (pt_rd_en && !pt_rd_ready) begin
                if (cnt == lat) begin
                    pt_rd_ready = 1'b1;
                    pt_rd_data  = pt_word(pt_rd_vpn, salt);
                    cnt = 0;
                end else begin
                    cnt++;
                end
            end else begin
                pt_rd_ready = 1'b0;
                cnt = 0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One translation; exp_walk selects hit or miss timing checks.
    task automatic do_req(input logic [31:0] va, input bit exp_walk, input logic [23:0] pa,
                          input bit fault, input bit flush_walk, input string req);
        int  n = 0;
        bit  walked = 0;
        bit  prev_rdy = 0;
        bit  done = 0;
        bit  vpn_ok = 1;
        bit  stall_ok = 1;
        @(negedge clk); #1;
        check(req_ready == 1'b1, "R9", "ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_vaddr = va;
        @(posedge clk); #1;
        req_valid = 1'b0;
        while (!done && n < 60) begin
            @(negedge clk); #1;
            n++;
            if (resp_done) begin
                done = 1;
            end else begin
                if (pt_rd_en) begin
                    walked = 1;
                    if (pt_rd_vpn != va[31:12]) vpn_ok = 0;
                    if (req_ready) stall_ok = 0;
                    if (flush_walk) flush = 1'b1;
                end
                prev_rdy = pt_rd_ready;
            end
        end
        flush = 1'b0;
        if (exp_walk) begin
            check(done && walked && prev_rdy, "R3", "miss timing", 32'(n), 32'd0);
            check(vpn_ok, "R3", "walk index", {12'h0, pt_rd_vpn}, {12'h0, va[31:12]});
            check(stall_ok, "R9", "ready low during walk", 32'd1, 32'd0);
        end else begin
            check(done && n == 1 && !walked, "R2", "hit timing", 32'(n), 32'd1);
        end
        check(resp_fault == fault, fault ? "R4" : req, "fault flag", 32'(resp_fault), 32'(fault));
        check(resp_paddr == pa, req, "physical address", {8'h0, resp_paddr}, {8'h0, pa});
    endtask

    task automatic pulse_flush();
        @(negedge clk); #1;
        flush = 1'b1;
        #1;
        check(req_ready == 1'b0, "R8", "ready low during flush", 32'(req_ready), 32'd0);
        @(negedge clk); #1;
        flush = 1'b0;
    endtask

    // Vectors: {logical address, expect walk}. Frames come from pt_word.
    localparam logic [32:0] VECS [0:7] = '{
        {32'h0001_2345, 1'b1},
        {32'h0001_2ABC, 1'b0},
        {32'h0B00_1001, 1'b1},
        {32'h0B00_1002, 1'b1},
        {32'hFFFF_F123, 1'b1},
        {32'hFFFF_FFFF, 1'b0},
        {32'h0001_2000, 1'b0},
        {32'h1234_5F05, 1'b1}
    };

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R10 reset state
        check(req_ready == 1'b1, "R10", "reset ready", 32'(req_ready), 32'd1);
        check(resp_done == 1'b0, "R10", "reset done", 32'(resp_done), 32'd0);
        check(pt_rd_en == 1'b0, "R10", "reset walk", 32'(pt_rd_en), 32'd0);

        // Table walk: R1 pass-through, R2 hits, R3 misses, R4 faults not installed
        for (int i = 0; i < 8; i++) begin
            logic [31:0] va;
            va  = VECS[i][32:1];
            lat = i % 4;
            do_req(va, VECS[i][0], exp_pa(va, 12'h0), !pt_word(va[31:12], 12'h0)[12], 1'b0, "R1");
        end

        // R5: table changes, cached frame still returned
        salt = 12'h111;
        do_req(32'h0001_2777, 1'b0, exp_pa(32'h0001_2777, 12'h0), 1'b0, 1'b0, "R5");

        // R8: flush forces refetch of the new frame
        pulse_flush();
        do_req(32'h0001_2777, 1'b1, exp_pa(32'h0001_2777, 12'h111), 1'b0, 1'b0, "R8");
        salt = 12'h0;

        // R8: flush across the install edge drops the install
        lat = 2;
        do_req(32'h0005_5010, 1'b1, exp_pa(32'h0005_5010, 12'h0), 1'b0, 1'b1, "R8");
        do_req(32'h0005_5020, 1'b1, exp_pa(32'h0005_5020, 12'h0), 1'b0, 1'b0, "R8");

        // R6: 64 distinct pages fill free slots and all stay resident
        pulse_flush();
        lat = 0;
        for (int i = 0; i < 64; i++) begin
            logic [31:0] va;
            va = {20'h40000 + 20'(i), 12'h0AB};
            do_req(va, 1'b1, exp_pa(va, 12'h0), 1'b0, 1'b0, "R6");
        end
        for (int i = 0; i < 64; i++) begin
            logic [31:0] va;
            va = {20'h40000 + 20'(i), 12'h5CD};
            do_req(va, 1'b0, exp_pa(va, 12'h0), 1'b0, 1'b0, "R6");
        end

        // R7: round-robin replacement from entry 0
        do_req(32'h4004_0001, 1'b1, exp_pa(32'h4004_0001, 12'h0), 1'b0, 1'b0, "R7");
        do_req(32'h4000_1002, 1'b0, exp_pa(32'h4000_1002, 12'h0), 1'b0, 1'b0, "R7");
        do_req(32'h4000_0003, 1'b1, exp_pa(32'h4000_0003, 12'h0), 1'b0, 1'b0, "R7");
        do_req(32'h4000_2004, 1'b0, exp_pa(32'h4000_2004, 12'h0), 1'b0, 1'b0, "R7");
        do_req(32'h4000_1005, 1'b1, exp_pa(32'h4000_1005, 12'h0), 1'b0, 1'b0, "R7");
        do_req(32'h4004_0006, 1'b0, exp_pa(32'h4004_0006, 12'h0), 1'b0, 1'b0, "R7");

        @(negedge clk); #1;
        check(resp_done == 1'b0, "R2", "done is a single pulse", 32'(resp_done), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule